// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the node's precision-time clock. The clock is a 102-bit value made of three fields: 48 bits of seconds, 30 bits of nanoseconds and a 24-bit binary fraction of a nanosecond. On every cycle of the timestamp clock, a programmed whole-nanosecond increment and a programmed fractional increment are added. A carry out of the fraction adds one extra nanosecond, and the nanoseconds wrap into the seconds at one billion. Because the fraction accumulates, the clock can track an oscillator whose period is not a whole number of nanoseconds.

Software reaches the clock through a small word-wide register port. Through it, software can load the seconds in two parts, load the nanoseconds, program both increments and request an atomic step of up to about one second in either direction. The block normalises the step into the seconds field by itself. The live time is driven on dedicated outputs so that capture logic elsewhere can sample it on a frame event. Writing zero to both increments freezes the clock.

Top module: `tod_clock`

## Requirements
- R1: After reset the seconds, nanoseconds and fraction are zero, both increments read back as zero, and the time stays at zero until software programs an increment.
- R2: In a cycle with no time write, the fraction becomes (fraction + fractional increment) mod 2^24, and the nanoseconds gain the whole increment plus one when that fractional addition overflowed. The whole increment is bits [7:0] written at address 0x4.
- R3: When the nanosecond sum reaches 1,000,000,000 or more, one billion is subtracted and the seconds increase by one. The seconds wrap from 2^48-1 to 0. The nanoseconds never hold a value of one billion or above.
- R4: At address 0x5, write-data bits [15:0] become fraction-increment bits [23:8] and bits [31:24] become fraction-increment bits [7:0]. Bits [23:16] are ignored and read back as zero, and a read returns the same split layout.
- R5: A write to address 0x0 loads seconds [31:0]. A write to address 0x1 loads seconds [47:32] from bits [15:0]. In that cycle the other time fields hold their values and no increment is applied.
- R6: A write to address 0x2 with bits [29:0] below one billion loads the nanoseconds and clears the fraction. A value of one billion or above is ignored and leaves the whole time unchanged. In either case no increment is applied in that cycle.
- R7: A write to address 0x3 steps the nanoseconds by the magnitude in bits [29:0], subtracting when bit 31 is 1 and adding when it is 0. The result is brought back into [0, 1e9) by adding or removing whole seconds, up to two of them. The fraction is kept, and no increment is applied in that cycle.
- R8: With both increments at zero and no writes, the time holds its value on every cycle.
- R9: Reads return values combinationally from the current state:
  - 0x0 gives seconds [31:0];
  - 0x1 gives seconds [47:32] in bits [15:0];
  - 0x2 gives the nanoseconds;
  - 0x4 gives the whole increment.
  
  Address 0x3 and the unmapped addresses 0x6 to 0xF read as zero.
- R10: An increment write takes effect from the cycle after the write. The cycle of the write itself still advances the time with the old increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock; the time advances on each rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 4 | Register address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| todSec | output | 48 | Current seconds |
| todNs | output | 30 | Current nanoseconds |
| todSub | output | 24 | Current fractional nanoseconds |

## Verification
The time is advanced under a grid of whole and fractional increments. The fractional values are chosen to separate the case where the fraction never carries, the case where it carries on every cycle, and the case where it carries every other cycle. Each setting is started just below a nanosecond rollover while the seconds sit at their all-ones value, so that the carry into the seconds and the 48-bit wrap are distinguished from plain counting. Steps are swept over start points near 0 and near one billion and over magnitudes from zero to the maximum. Together these reach single and double borrows and carries in both directions. Rejected nanosecond loads, partial seconds loads and the one-cycle delay of an increment change are checked against the same arithmetic model.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int BUS_W        = 32;
  localparam int ADDR_W       = 4;
  localparam int STEP_SUB_BIT = 31;
  localparam int SUB_LO_W     = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC_LO  = 4'h0,
    REG_SEC_HI  = 4'h1,
    REG_NSEC    = 4'h2,
    REG_STEP    = 4'h3,
    REG_NS_INC  = 4'h4,
    REG_SUB_INC = 4'h5
  } todReg_e;

  typedef struct packed {
    logic loadSecLo;
    logic loadSecHi;
    logic loadNs;
    logic stepAdj;
  } todStrobe_t;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30,
  parameter int SUB_W    = 24,
  parameter int NS_INC_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWrData,
  input  logic [SEC_W-1:0]    curSec,
  input  logic [NS_W-1:0]     curNs,
  output todStrobe_t          strobe,
  output logic [NS_INC_W-1:0] nsInc,
  output logic [SUB_W-1:0]    subInc,
  output logic [BUS_W-1:0]    busRdData
);

  localparam int SUB_HI_W = SUB_W - SUB_LO_W;
  localparam int GAP_W    = BUS_W - SUB_W;

  logic [NS_INC_W-1:0] nsIncQ;
  logic [SUB_W-1:0]    subIncQ;
  logic [GAP_W-1:0]    unusedWrGap;

  assign unusedWrGap = busWrData[BUS_W-SUB_LO_W-1:SUB_HI_W];

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      case (busAddr)
        REG_SEC_LO: strobe.loadSecLo = 1'b1;
        REG_SEC_HI: strobe.loadSecHi = 1'b1;
        REG_NSEC:   strobe.loadNs    = 1'b1;
        REG_STEP:   strobe.stepAdj   = 1'b1;
        default:    strobe           = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nsIncQ  <= '0;
      subIncQ <= '0;
    end else if (busWrEn) begin
      if (busAddr == REG_NS_INC)
        nsIncQ <= busWrData[NS_INC_W-1:0];
      if (busAddr == REG_SUB_INC)
        subIncQ <= {busWrData[SUB_HI_W-1:0], busWrData[BUS_W-1:BUS_W-SUB_LO_W]};
    end
  end

  assign nsInc  = nsIncQ;
  assign subInc = subIncQ;

  always_comb begin
    case (busAddr)
      REG_SEC_LO:  busRdData = curSec[BUS_W-1:0];
      REG_SEC_HI:  busRdData = BUS_W'(curSec[SEC_W-1:BUS_W]);
      REG_NSEC:    busRdData = BUS_W'(curNs);
      REG_NS_INC:  busRdData = BUS_W'(nsIncQ);
      REG_SUB_INC: busRdData = {subIncQ[SUB_LO_W-1:0], {GAP_W{1'b0}}, subIncQ[SUB_W-1:SUB_LO_W]};
      default:     busRdData = '0;
    endcase
  end

  AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(nsIncQ) && $stable(subIncQ)))
    else $error("increment changed without a write"); // R10

  AST_ONE_TIME_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe))
    else $error("more than one time strobe"); // R5

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int          SEC_W      = 48,
  parameter int          NS_W       = 30,
  parameter int          SUB_W      = 24,
  parameter int          NS_INC_W   = 8,
  parameter int unsigned NS_PER_SEC = 1000000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  todStrobe_t          strobe,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [NS_INC_W-1:0] nsInc,
  input  logic [SUB_W-1:0]    subInc,
  output logic [SEC_W-1:0]    secOut,
  output logic [NS_W-1:0]     nsOut,
  output logic [SUB_W-1:0]    subOut
);

  localparam int SEC_HI_W = SEC_W - BUS_W;
  localparam int NSX      = NS_W + 3;
  localparam logic signed [NSX-1:0] ONE_B = NSX'(NS_PER_SEC);
  localparam logic signed [NSX-1:0] TWO_B = ONE_B + ONE_B;
  localparam logic [NS_W:0]   ONE_T  = (NS_W + 1)'(NS_PER_SEC);
  localparam logic [NS_W-1:0] ONE_NS = NS_W'(NS_PER_SEC);

  logic [SEC_W-1:0] secQ, secN;
  logic [NS_W-1:0]  nsQ, nsN;
  logic [SUB_W-1:0] subQ, subN;

  // tick arithmetic
  logic [SUB_W:0] subSum;
  logic [NS_W:0]  nsSum;
  logic           nsWrap;

  assign subSum = {1'b0, subQ} + {1'b0, subInc};
  assign nsSum  = {1'b0, nsQ} + (NS_W + 1)'(nsInc) + (NS_W + 1)'(subSum[SUB_W]);
  assign nsWrap = (nsSum >= ONE_T);

  // step arithmetic
  logic signed [NSX-1:0] nsX, magX, stepRaw, stepPlus;
  logic                  nsLoadOk;

  assign nsX      = NSX'(nsQ);
  assign magX     = NSX'(wrData[NS_W-1:0]);
  assign stepRaw  = wrData[STEP_SUB_BIT] ? (nsX - magX) : (nsX + magX);
  assign stepPlus = stepRaw + ONE_B;
  assign nsLoadOk = (wrData[NS_W-1:0] < ONE_NS);

  always_comb begin
    secN = secQ;
    nsN  = nsQ;
    subN = subQ;
    if (strobe.loadSecLo) begin
      secN[BUS_W-1:0] = wrData;
    end else if (strobe.loadSecHi) begin
      secN[SEC_W-1:BUS_W] = wrData[SEC_HI_W-1:0];
    end else if (strobe.loadNs) begin
      if (nsLoadOk) begin
        nsN  = wrData[NS_W-1:0];
        subN = '0;
      end
    end else if (strobe.stepAdj) begin
      if (stepRaw < 0) begin
        if (stepPlus < 0) begin
          nsN  = NS_W'(stepRaw + TWO_B);
          secN = secQ - SEC_W'(2);
        end else begin
          nsN  = NS_W'(stepPlus);
          secN = secQ - SEC_W'(1);
        end
      end else if (stepRaw >= TWO_B) begin
        nsN  = NS_W'(stepRaw - TWO_B);
        secN = secQ + SEC_W'(2);
      end else if (stepRaw >= ONE_B) begin
        nsN  = NS_W'(stepRaw - ONE_B);
        secN = secQ + SEC_W'(1);
      end else begin
        nsN  = NS_W'(stepRaw);
      end
    end else begin
      subN = subSum[SUB_W-1:0];
      if (nsWrap) begin
        nsN  = NS_W'(nsSum - ONE_T);
        secN = secQ + SEC_W'(1);
      end else begin
        nsN  = nsSum[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0;
      nsQ  <= '0;
      subQ <= '0;
    end else begin
      secQ <= secN;
      nsQ  <= nsN;
      subQ <= subN;
    end
  end

  assign secOut = secQ;
  assign nsOut  = nsQ;
  assign subOut = subQ;

  AST_NS_BELOW_BILLION: assert property (@(posedge clk) disable iff (!rstN)
    nsQ < ONE_NS)
    else $error("nanoseconds out of range"); // R3

  AST_SEC_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> (secQ == $past(secQ) || secQ == $past(secQ) + 1'b1))
    else $error("seconds jumped during a tick"); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0 && nsInc == '0 && subInc == '0) |=>
      ($stable(secQ) && $stable(nsQ) && $stable(subQ)))
    else $error("time moved with zero increments"); // R8

  AST_NS_LOAD_CLEARS_SUB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadNs && wrData[NS_W-1:0] < ONE_NS) |=>
      (subQ == '0 && nsQ == $past(wrData[NS_W-1:0])))
    else $error("nanosecond load wrong"); // R6

  AST_STEP_KEEPS_SUB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepAdj |=> $stable(subQ))
    else $error("step touched the fraction"); // R7

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic [47:0] todSec,
  output logic [29:0] todNs,
  output logic [23:0] todSub
);

  localparam int SEC_W    = 48;
  localparam int NS_W     = 30;
  localparam int SUB_W    = 24;
  localparam int NS_INC_W = 8;

  todStrobe_t          strobe;
  logic [NS_INC_W-1:0] nsInc;
  logic [SUB_W-1:0]    subInc;

  tod_ctrl #(
    .SEC_W(SEC_W), .NS_W(NS_W), .SUB_W(SUB_W), .NS_INC_W(NS_INC_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .curSec(todSec), .curNs(todNs),
    .strobe(strobe), .nsInc(nsInc), .subInc(subInc), .busRdData(busRdData)
  );

  tod_datapath #(
    .SEC_W(SEC_W), .NS_W(NS_W), .SUB_W(SUB_W), .NS_INC_W(NS_INC_W),
    .NS_PER_SEC(1000000000)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .nsInc(nsInc), .subInc(subInc),
    .secOut(todSec), .nsOut(todNs), .subOut(todSub)
  );

endmodule

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;

  localparam longint BILLION = 1000000000;
  localparam longint MASK48  = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn;
  logic [3:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic [47:0] todSec;
  logic [29:0] todNs;
  logic [23:0] todSub;

  always #2 clk = ~clk;

  tod_clock dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .todSec(todSec), .todNs(todNs), .todSub(todSub)
  );

  int     vecs = 0;
  int     errs = 0;
  bit     finished = 1'b0;
  string  curTag = "R1";
  longint mSec, mNs, mSub, mNsInc, mSubInc;

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      4'h0: modelRead = mSec[31:0];
      4'h1: modelRead = {16'h0, mSec[47:32]};
      4'h2: modelRead = {2'b00, mNs[29:0]};
      4'h4: modelRead = {24'h0, mNsInc[7:0]};
      4'h5: modelRead = {mSubInc[7:0], 8'h00, mSubInc[23:8]};
      default: modelRead = 32'h0;
    endcase
  endfunction

  task automatic modelTick();
    longint s;
    s = mSub + mSubInc;
    mSub = s & 64'hFF_FFFF;
    mNs = mNs + mNsInc + (s >> 24);
    if (mNs >= BILLION) begin
      mNs = mNs - BILLION;
      mSec = (mSec + 1) & MASK48;
    end
  endtask

  task automatic modelEdge(input bit we, input logic [3:0] a, input logic [31:0] d);
    longint t;
    if (!we) modelTick();
    else begin
      case (a)
        4'h0: mSec = (mSec & 64'h0000_FFFF_0000_0000) | longint'(d);
        4'h1: mSec = (mSec & 64'h0000_0000_FFFF_FFFF) | (longint'(d[15:0]) << 32);
        4'h2: if (longint'(d[29:0]) < BILLION) begin mNs = longint'(d[29:0]); mSub = 0; end
        4'h3: begin
          t = d[31] ? (mNs - longint'(d[29:0])) : (mNs + longint'(d[29:0]));
          while (t < 0) begin t = t + BILLION; mSec = (mSec - 1) & MASK48; end
          while (t >= BILLION) begin t = t - BILLION; mSec = (mSec + 1) & MASK48; end
          mNs = t;
        end
        4'h4: begin modelTick(); mNsInc = longint'(d[7:0]); end
        4'h5: begin modelTick(); mSubInc = longint'({d[15:0], d[31:24]}); end
        default: modelTick();
      endcase
    end
  endtask

  task automatic checkTime();
    check(curTag, "time", {26'h0, todSec, todNs, todSub},
          {26'h0, mSec[47:0], mNs[29:0], mSub[23:0]});
  endtask

  task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d;
    if (!we) begin
      #1;
      check((a == 4'h5) ? "R4" : "R9", "read", {96'h0, busRdData}, {96'h0, modelRead(a)});
    end
    @(posedge clk);
    modelEdge(we, a, d);
    #1;
    checkTime();
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = 4'h0; busWrData = 32'h0;
    mSec = 0; mNs = 0; mSub = 0; mNsInc = 0; mSubInc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    curTag = "R1";
    checkTime();
    busAddr = 4'h4; #1;
    check("R1", "nsInc reset", {96'h0, busRdData}, 128'h0);
    busAddr = 4'h5; #1;
    check("R1", "subInc reset", {96'h0, busRdData}, 128'h0);

    curTag = "R8";
    idle(12, 4'h2);

    curTag = "R4";
    cyc(1'b1, 4'h5, 32'hC5FF_3A7E);
    idle(1, 4'h5);
    curTag = "R10";
    cyc(1'b1, 4'h4, 32'h0000_0108);
    idle(2, 4'h4);
    curTag = "R2";
    idle(40, 4'h2);

    // sweep of increments near a nanosecond rollover with seconds at all ones
    foreach (mSub[i]) ;
    for (int ni = 0; ni < 4; ni++) begin
      for (int si = 0; si < 5; si++) begin
        logic [7:0]  nI;
        logic [23:0] sI;
        nI = (ni == 0) ? 8'd0 : (ni == 1) ? 8'd1 : (ni == 2) ? 8'd7 : 8'd255;
        sI = (si == 0) ? 24'h0 : (si == 1) ? 24'h1 : (si == 2) ? 24'h800000 :
             (si == 3) ? 24'hFFFFFF : 24'h555555;
        curTag = "R10";
        cyc(1'b1, 4'h4, {24'h0, nI});
        cyc(1'b1, 4'h5, {sI[7:0], 8'h00, sI[23:8]});
        curTag = "R5";
        cyc(1'b1, 4'h0, 32'hFFFF_FFFF);
        cyc(1'b1, 4'h1, 32'h0000_FFFF);
        curTag = "R6";
        cyc(1'b1, 4'h2, 32'd999_999_700);
        curTag = (nI == 0 && sI == 0) ? "R8" : "R3";
        idle(40, 4'h0);
      end
    end

    curTag = "R6";
    cyc(1'b1, 4'h4, 32'd3);
    cyc(1'b1, 4'h5, 32'h4000_1234);
    idle(3, 4'h2);
    cyc(1'b1, 4'h2, 32'd1_000_000_000);
    cyc(1'b1, 4'h2, 32'h3FFF_FFFF);
    cyc(1'b1, 4'h2, 32'hC000_0010);
    idle(3, 4'h2);

    curTag = "R7";
    for (int st = 0; st < 3; st++) begin
      for (int mg = 0; mg < 6; mg++) begin
        for (int sg = 0; sg < 2; sg++) begin
          logic [29:0] mag;
          logic [31:0] start;
          start = (st == 0) ? 32'd0 : (st == 1) ? 32'd5 : 32'd999_999_990;
          mag = (mg == 0) ? 30'd0 : (mg == 1) ? 30'd1 : (mg == 2) ? 30'd500_000_000 :
                (mg == 3) ? 30'd999_999_999 : (mg == 4) ? 30'd1_000_000_000 : 30'h3FFF_FFFF;
          cyc(1'b1, 4'h0, 32'd100);
          cyc(1'b1, 4'h1, 32'd0);
          cyc(1'b1, 4'h2, start);
          cyc(1'b1, 4'h3, {sg[0], 1'b0, mag});
          idle(2, 4'h0);
        end
      end
    end

    curTag = "R9";
    for (int a = 3; a < 16; a++) idle(1, 4'(a));

    curTag = "R8";
    cyc(1'b1, 4'h4, 32'h0);
    cyc(1'b1, 4'h5, 32'h0);
    idle(10, 4'h1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule